// File: doc/BRIEF.md
# Host-to-Half-Word Bus Access Splitter

This block sits between a 32-bit host access path and a peripheral bus that is usually only 16 bits wide. It takes one host request (address, byte enables, write data, direction and a set of per-slot mode bits) and runs the matching transfers on the peripheral side. Byte and half-word requests go out as one transfer. A full 32-bit request to a narrow slot becomes two half-word transfers in a fixed order, the second one either to the next half-word address or back to the same address. A slot marked as 32-bit capable takes the full word in one wide transfer.

Two per-slot options reorder the data lanes: one exchanges the two bytes of every half-word, the other exchanges the two half-words of a full word. The same reordering is applied to write data before it is split and to read data after it is reassembled, so a value written and read back through the same settings comes back unchanged. When the access is finished the block raises a one-cycle done pulse; for reads, the assembled word is then available on the read-data output. An abort input, driven for example by an access timer, ends a sequence at once and still produces the done pulse.

Top module: `hbus_splitter`

## Requirements
- R1: After reset the block is idle: busy, the peripheral strobe and done are low and the read-data output is zero.
- R2: A request whose byte enables are not all ones runs as exactly one transfer at the request address, with per_wide low; with both swap bits clear the byte enables and data lanes pass straight through, and a read returns the peripheral data unchanged.
- R3: A full-word request (byte enables 4'b1111) to a 16-bit slot in incrementing mode runs two transfers: the first at the request address carrying host bits 15:0 in peripheral bits 15:0, the second at the address plus 2 (modulo 2^ADDR_W) carrying host bits 31:16 in peripheral bits 15:0; both use byte enables 4'b0011 with peripheral bits 31:16 zero.
- R4: In static mode the second half-word transfer of a split goes to the same address as the first.
- R5: On a split read the first returned half-word (peripheral bits 15:0) is held; done rises only after the second acknowledge, and the read data is {second half-word, first half-word}.
- R6: A full-word request to a slot marked 32-bit runs one transfer with per_wide high, byte enables 4'b1111 and the whole 32-bit word on the data lanes.
- R7: With the byte-swap bit set, byte lane i exchanges with lane i XOR 1 in write data, byte enables and read data, for every access size.
- R8: With the word-swap bit set, a full-word access exchanges its two 16-bit halves (so a split sends host bits 31:16 first); on byte and half-word requests the word-swap bit has no effect.
- R9: A request presented while busy is ignored: the running sequence keeps its address, enables and data and completes as if no request had arrived.
- R10: An abort while busy ends the sequence at the next edge: busy and strobe drop, done pulses for one cycle, and an aborted read returns all ones.
- R11: The strobe stays high with stable address, enables and data until an edge where the acknowledge is high; each such edge completes one transfer, and done is a single-cycle pulse in the cycle after the last one, with busy already low. Writes leave the read-data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present; taken when busy is low |
| req_addr | input | ADDR_W | Host byte address |
| req_be | input | 4 | Host byte enables; 4'b1111 marks a full word |
| req_wdata | input | 32 | Host write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_static | input | 1 | 1 = second half of a split reuses the address |
| req_bswap | input | 1 | Exchange bytes within each half-word |
| req_wswap | input | 1 | Exchange half-words of a full word |
| req_slot32 | input | 1 | Slot takes full words in one transfer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data |
| abort | input | 1 | Ends the running sequence at once |
| per_strb | output | 1 | Peripheral transfer strobe |
| per_write | output | 1 | Peripheral transfer direction |
| per_wide | output | 1 | Transfer uses all 32 data bits |
| per_addr | output | ADDR_W | Peripheral byte address |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | 32 | Peripheral read data |

## Verification
The bench builds the block with ADDR_W set to 12, small enough that a split in incrementing mode can start on the last half-word of the address space and its second transfer wraps to address zero. Byte width and the increment step stay at their defaults, so the byte-lane and half-word orderings checked are those of a 32-bit host and a 16-bit slot. The peripheral model varies its acknowledge delay, which keeps the strobe waiting long enough to offer a second request and an abort in the middle of a split.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_FIRST  = 2'd1,
      SEQ_SECOND = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic write;
      logic hold_addr;
      logic bswap;
      logic wswap;
      logic split;
      logic wide;
   } acc_mode_t;

endpackage

// File: rtl/hbs_lane_swap.sv
// Byte-lane permutation: output lane i takes input lane i ^ {wswap, bswap}.
module hbs_lane_swap #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic [LANES*BYTE_W-1:0] d_in,
   input  logic [LANES-1:0]        be_in,
   input  logic                    bswap,
   input  logic                    wswap,
   output logic [LANES*BYTE_W-1:0] d_out,
   output logic [LANES-1:0]        be_out
);
   if (LANES != 4) begin : g_bad_lanes
      $error("hbs_lane_swap needs exactly four byte lanes");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [1:0] src;
      assign src = 2'(i) ^ {wswap, bswap};
      assign d_out[i*BYTE_W +: BYTE_W] = d_in[src*BYTE_W +: BYTE_W];
      assign be_out[i] = be_in[src];
   end
endmodule

// File: rtl/hbs_seq.sv
// Sequence controller: one or two transfers per accepted request.
module hbs_seq
   import hbs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic split,
   input  logic ack_ev,
   input  logic abort,
   output logic busy,
   output logic in_second,
   output logic latch_lo,
   output logic finish
);
   seq_state_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE:   if (start) state_q <= SEQ_FIRST;
            SEQ_FIRST: begin
               if (abort)       state_q <= SEQ_IDLE;
               else if (ack_ev) state_q <= split ? SEQ_SECOND : SEQ_IDLE;
            end
            SEQ_SECOND: if (abort || ack_ev) state_q <= SEQ_IDLE;
            default:    state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SEQ_IDLE);
   assign in_second = (state_q == SEQ_SECOND);
   assign latch_lo  = (state_q == SEQ_FIRST) && ack_ev && !abort && split;
   assign finish    = busy && (abort || (ack_ev && (in_second || !split)));
endmodule

// File: rtl/hbs_rd_asm.sv
// Read assembly: holds the first half-word of a split and reorders the result.
module hbs_rd_asm #(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  latch_lo,
   input  logic                  finish,
   input  logic                  abort,
   input  logic                  is_write,
   input  logic                  split,
   input  logic                  bswap,
   input  logic                  wswap,
   input  logic [4*BYTE_W-1:0]   per_rdata,
   output logic [4*BYTE_W-1:0]   rdata
);
   localparam int HALF_W = 2 * BYTE_W;
   localparam int WORD_W = 4 * BYTE_W;

   logic [HALF_W-1:0] lo_q;
   logic [WORD_W-1:0] raw;
   logic [WORD_W-1:0] ordered;
   logic [3:0]        be_unused;
   logic [WORD_W-1:0] rdata_q;

   assign raw = split ? {per_rdata[HALF_W-1:0], lo_q} : per_rdata;

   hbs_lane_swap #(.BYTE_W(BYTE_W), .LANES(4)) u_rd_swap (
      .d_in   (raw),
      .be_in  (4'hF),
      .bswap  (bswap),
      .wswap  (wswap),
      .d_out  (ordered),
      .be_out (be_unused)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         rdata_q <= '0;
      end else begin
         if (latch_lo) lo_q <= per_rdata[HALF_W-1:0];
         if (finish && !is_write) rdata_q <= abort ? '1 : ordered;
      end
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/hbus_splitter.sv
module hbus_splitter
   import hbs_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int BYTE_W   = 8,
   parameter int INC_STEP = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [3:0]          req_be,
   input  logic [4*BYTE_W-1:0] req_wdata,
   input  logic                req_write,
   input  logic                req_static,
   input  logic                req_bswap,
   input  logic                req_wswap,
   input  logic                req_slot32,
   output logic                busy,
   output logic                done,
   output logic [4*BYTE_W-1:0] rdata,
   input  logic                abort,
   output logic                per_strb,
   output logic                per_write,
   output logic                per_wide,
   output logic [ADDR_W-1:0]   per_addr,
   output logic [3:0]          per_be,
   output logic [4*BYTE_W-1:0] per_wdata,
   input  logic                per_ack,
   input  logic [4*BYTE_W-1:0] per_rdata
);
   localparam int HALF_W = 2 * BYTE_W;
   localparam int WORD_W = 4 * BYTE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("hbus_splitter: ADDR_W must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("hbus_splitter: BYTE_W must be positive");
   end
   if (INC_STEP < 1 || INC_STEP >= (1 << ADDR_W)) begin : g_bad_step
      $error("hbus_splitter: INC_STEP out of range");
   end

   logic        accept;
   logic        is_long;
   logic        seq_busy;
   logic        in_second;
   logic        latch_lo;
   logic        finish;
   logic        ack_ev;

   logic [WORD_W-1:0] wd_sw;
   logic [3:0]        be_sw;

   acc_mode_t         mode_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wd_q;
   logic [3:0]        be_q;
   logic              done_q;

   assign is_long = &req_be;
   assign accept  = req_valid && !seq_busy;
   assign ack_ev  = seq_busy && per_ack;

   hbs_lane_swap #(.BYTE_W(BYTE_W), .LANES(4)) u_wr_swap (
      .d_in   (req_wdata),
      .be_in  (req_be),
      .bswap  (req_bswap),
      .wswap  (req_wswap && is_long),
      .d_out  (wd_sw),
      .be_out (be_sw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         addr_q <= '0;
         wd_q   <= '0;
         be_q   <= '0;
      end else if (accept) begin
         mode_q.write     <= req_write;
         mode_q.hold_addr <= req_static;
         mode_q.bswap     <= req_bswap;
         mode_q.wswap     <= req_wswap && is_long;
         mode_q.split     <= is_long && !req_slot32;
         mode_q.wide      <= is_long && req_slot32;
         addr_q           <= req_addr;
         wd_q             <= wd_sw;
         be_q             <= be_sw;
      end
   end

   hbs_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .split     (mode_q.split),
      .ack_ev    (ack_ev),
      .abort     (abort),
      .busy      (seq_busy),
      .in_second (in_second),
      .latch_lo  (latch_lo),
      .finish    (finish)
   );

   hbs_rd_asm #(.BYTE_W(BYTE_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_lo  (latch_lo),
      .finish    (finish),
      .abort     (abort),
      .is_write  (mode_q.write),
      .split     (mode_q.split),
      .bswap     (mode_q.bswap),
      .wswap     (mode_q.wswap),
      .per_rdata (per_rdata),
      .rdata     (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= finish;
   end

   logic [ADDR_W-1:0] second_addr;
   assign second_addr = mode_q.hold_addr ? addr_q : addr_q + ADDR_W'(INC_STEP);

   always_comb begin
      per_addr  = in_second ? second_addr : addr_q;
      per_be    = mode_q.split ? 4'b0011 : be_q;
      per_wdata = wd_q;
      if (mode_q.split) begin
         per_wdata = {{HALF_W{1'b0}},
                      (in_second ? wd_q[WORD_W-1:HALF_W] : wd_q[HALF_W-1:0])};
      end
   end

   assign busy      = seq_busy;
   assign done      = done_q;
   assign per_strb  = seq_busy;
   assign per_write = seq_busy && mode_q.write;
   assign per_wide  = seq_busy && mode_q.wide;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              abort,
   input logic              per_strb,
   input logic              per_ack,
   input logic              per_wide,
   input logic [ADDR_W-1:0] per_addr,
   input logic [3:0]        per_be
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R11

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(per_strb && per_ack) && !abort) |=>
         (busy && $stable(per_addr) && $stable(per_be))); // R9

   AST_WIDE_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
      per_wide |-> (per_be == 4'hF && per_strb)); // R6

   AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort) |=> (done && !busy && !per_strb)); // R10
endmodule

bind hbus_splitter hbs_checker #(.ADDR_W(ADDR_W)) u_hbs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .abort    (abort),
   .per_strb (per_strb),
   .per_ack  (per_ack),
   .per_wide (per_wide),
   .per_addr (per_addr),
   .per_be   (per_be)
);

// File: tb/hbus_splitter_bench.sv
`timescale 1ns/1ps
module hbus_splitter_bench;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_be = '0;
   logic [31:0]   req_wdata = '0;
   logic          req_write = 1'b0;
   logic          req_static = 1'b0;
   logic          req_bswap = 1'b0;
   logic          req_wswap = 1'b0;
   logic          req_slot32 = 1'b0;
   logic          busy, done;
   logic [31:0]   rdata;
   logic          abort = 1'b0;
   logic          per_strb, per_write, per_wide;
   logic [AW-1:0] per_addr;
   logic [3:0]    per_be;
   logic [31:0]   per_wdata;
   logic          per_ack = 1'b0;
   logic [31:0]   per_rdata = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   hbus_splitter #(.ADDR_W(AW)) u_hbus_splitter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata), .req_write(req_write),
      .req_static(req_static), .req_bswap(req_bswap), .req_wswap(req_wswap),
      .req_slot32(req_slot32), .busy(busy), .done(done), .rdata(rdata),
      .abort(abort), .per_strb(per_strb), .per_write(per_write),
      .per_wide(per_wide), .per_addr(per_addr), .per_be(per_be),
      .per_wdata(per_wdata), .per_ack(per_ack), .per_rdata(per_rdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] bsw(input logic [31:0] d);
      return {d[23:16], d[31:24], d[7:0], d[15:8]};
   endfunction
   function automatic logic [31:0] wsw(input logic [31:0] d);
      return {d[15:0], d[31:16]};
   endfunction
   function automatic logic [3:0] bsw_be(input logic [3:0] b);
      return {b[2], b[3], b[0], b[1]};
   endfunction

   // Reference model: expected transfer list and read result per request.
   logic [AW-1:0] q_addr[$];
   logic [31:0]   q_wd[$];
   logic [3:0]    q_be[$];
   logic          q_wide[$];

   task automatic run_op(input string req, input bit wr, input logic [3:0] be,
                         input logic [AW-1:0] a, input logic [31:0] wd,
                         input bit st, input bit bs, input bit ws, input bit s32,
                         input int delay, input int abort_at, input bit inject,
                         input logic [31:0] r1, input logic [31:0] r2);
      bit lng = (be == 4'hF);
      bit wse = ws && lng;
      logic [31:0] sw, raw, exp_rd, prev_rd;
      int n;
      bit aborted = 0;
      sw = wd;
      if (bs) sw = bsw(sw);
      if (wse) sw = wsw(sw);
      q_addr.delete(); q_wd.delete(); q_be.delete(); q_wide.delete();
      if (lng && !s32) begin
         q_addr.push_back(a);  q_wd.push_back({16'h0, sw[15:0]});
         q_be.push_back(4'h3); q_wide.push_back(1'b0);
         q_addr.push_back(st ? a : AW'(a + 2)); q_wd.push_back({16'h0, sw[31:16]});
         q_be.push_back(4'h3); q_wide.push_back(1'b0);
         raw = {r2[15:0], r1[15:0]};
      end else if (lng) begin
         q_addr.push_back(a); q_wd.push_back(sw);
         q_be.push_back(4'hF); q_wide.push_back(1'b1);
         raw = r1;
      end else begin
         q_addr.push_back(a); q_wd.push_back(sw);
         q_be.push_back(bs ? bsw_be(be) : be); q_wide.push_back(1'b0);
         raw = r1;
      end
      exp_rd = raw;
      if (bs) exp_rd = bsw(exp_rd);
      if (wse) exp_rd = wsw(exp_rd);
      prev_rd = rdata;

      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_be = be; req_wdata = wd;
      req_write = wr; req_static = st; req_bswap = bs; req_wswap = ws;
      req_slot32 = s32;
      @(negedge clk);
      req_valid = 1'b0;
      n = q_addr.size();
      for (int t = 0; t < n; t++) begin
         for (int d = 0; d <= delay; d++) begin
            check(per_strb === 1'b1 && busy === 1'b1, req, "strobe/busy", {per_strb, busy}, 2'b11);
            check(done === 1'b0, "R11", "done early", done, 0);
            check(per_addr === q_addr[t], req, "addr", per_addr, q_addr[t]);
            check(per_be === q_be[t], req, "be", per_be, q_be[t]);
            check(per_wide === q_wide[t], req, "wide", per_wide, q_wide[t]);
            check(per_write === wr, req, "dir", per_write, wr);
            if (wr) check(per_wdata === q_wd[t], req, "wdata", per_wdata, q_wd[t]);
            if (d < delay) begin
               if (inject && d == 0) begin
                  req_valid = 1'b1; req_addr = ~a; req_be = 4'h1; req_write = ~wr;
               end
               @(negedge clk);
               req_valid = 1'b0;
            end
         end
         if (abort_at == t) begin
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            aborted = 1;
            break;
         end
         per_ack = 1'b1;
         per_rdata = (t == 0) ? r1 : r2;
         @(negedge clk);
         per_ack = 1'b0;
         per_rdata = 32'hDEAD_BEEF;
      end
      check(done === 1'b1, aborted ? "R10" : "R11", "done pulse", done, 1);
      check(busy === 1'b0 && per_strb === 1'b0, aborted ? "R10" : "R11", "idle at done",
            {busy, per_strb}, 0);
      if (!wr) check(rdata === (aborted ? 32'hFFFF_FFFF : exp_rd), req, "rdata", rdata,
                     aborted ? 32'hFFFF_FFFF : exp_rd);
      else check(rdata === prev_rd, "R11", "rdata kept on write", rdata, prev_rd);
      @(negedge clk);
      check(done === 1'b0, "R11", "done single cycle", done, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && per_strb === 1'b0 && done === 1'b0, "R1", "idle in reset",
            {busy, per_strb, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && per_strb === 1'b0 && done === 1'b0, "R1", "idle after reset",
            {busy, per_strb, done}, 0);
      check(rdata === 32'h0, "R1", "rdata reset", rdata, 0);

      // R2: single transfers, straight lanes
      run_op("R2", 1, 4'b0011, 12'h010, 32'h1122_3344, 0, 0, 0, 0, 0, -1, 0, 0, 0);
      run_op("R2", 0, 4'b1100, 12'h102, 0, 0, 0, 0, 0, 1, -1, 0, 32'hA1B2_C3D4, 0);
      // R3: incrementing split, including wrap at the top of the space
      run_op("R3", 1, 4'hF, 12'h040, 32'hCAFE_F00D, 0, 0, 0, 0, 2, -1, 0, 0, 0);
      run_op("R3", 1, 4'hF, 12'hFFE, 32'h0123_4567, 0, 0, 0, 0, 0, -1, 0, 0, 0);
      // R4: static split
      run_op("R4", 1, 4'hF, 12'h200, 32'h89AB_CDEF, 1, 0, 0, 0, 1, -1, 0, 0, 0);
      // R5: split reads
      run_op("R5", 0, 4'hF, 12'h300, 0, 0, 0, 0, 0, 1, -1, 0, 32'h7777_1234, 32'h9999_5678);
      run_op("R5", 0, 4'hF, 12'h304, 0, 1, 1, 0, 0, 0, -1, 0, 32'h0000_A1B2, 32'hFFFF_C3D4);
      // R6: direct wide transfers
      run_op("R6", 1, 4'hF, 12'h400, 32'h5566_7788, 0, 0, 0, 1, 1, -1, 0, 0, 0);
      run_op("R6", 0, 4'hF, 12'h404, 0, 0, 0, 0, 1, 0, -1, 0, 32'h1357_9BDF, 0);
      // R7: byte swap on narrow accesses
      run_op("R7", 1, 4'b0001, 12'h500, 32'h0000_00AB, 0, 1, 0, 0, 0, -1, 0, 0, 0);
      run_op("R7", 0, 4'b0011, 12'h502, 0, 0, 1, 0, 0, 0, -1, 0, 32'h0000_BEEF, 0);
      run_op("R7", 1, 4'hF, 12'h508, 32'h1020_3040, 0, 1, 0, 0, 0, -1, 0, 0, 0);
      // R8: word swap on full words, ignored on narrow ones
      run_op("R8", 1, 4'hF, 12'h600, 32'hAAAA_5555, 0, 0, 1, 0, 0, -1, 0, 0, 0);
      run_op("R8", 1, 4'b0011, 12'h604, 32'h1234_5678, 0, 0, 1, 0, 0, -1, 0, 0, 0);
      run_op("R8", 0, 4'b1100, 12'h606, 0, 0, 0, 1, 0, 0, -1, 0, 32'hFACE_0000, 0);
      run_op("R8", 0, 4'hF, 12'h608, 0, 0, 1, 1, 1, 0, -1, 0, 32'h0102_0304, 0);
      // R9: request while busy is ignored
      run_op("R9", 1, 4'hF, 12'h700, 32'h600D_CAFE, 0, 0, 0, 0, 3, -1, 1, 0, 0);
      // R10: aborts in first and second transfer
      run_op("R10", 0, 4'hF, 12'h800, 0, 0, 0, 0, 0, 1, 1, 0, 32'h0000_1111, 32'h0000_2222);
      run_op("R10", 1, 4'hF, 12'h810, 32'h3333_4444, 0, 0, 0, 0, 2, 0, 0, 0, 0);
      // after an abort the block takes new work normally
      run_op("R5", 0, 4'hF, 12'h820, 0, 0, 0, 0, 0, 0, -1, 0, 32'h0000_BBBB, 32'h0000_AAAA);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule